// File: doc/BRIEF.md
# Multi-Link Receive Merger

This block sits on the receive side of a bridge between several slow serial links and a fast on-board router. Each link drives beats into its own deep FIFO. The FIFOs absorb the difference in rate between the links and the router, and they compete for one output stream. Each beat carries a data word and an end-of-packet flag.

A round-robin arbiter with rotating priority picks which FIFO feeds the output. It changes owner only after a packet's final beat has been handed over. The channel that finished most recently then drops to lowest priority. The output is a single registered stage with a valid/ready handshake. While the output is stalled, nothing moves and nothing is lost.

Toward each link the block raises a pause request when that link's FIFO fills past a high mark. It keeps the request up until the FIFO has drained to a low mark. The gap between the two marks absorbs the far end's reaction delay.

Top module: `link_merge_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `lnk_xoff` is 0.
- R2: Beats from one channel leave the output in the order they arrived, with data and end flag unchanged. Each beat is tagged on `out_src` with its channel index as a binary number.
- R3: Once the first beat of a packet from channel c has appeared on the output, every following beat comes from c until the beat of c with `out_last`=1.
- R4: When a packet from channel c ends, the next packet is taken from the first channel with a non-empty FIFO, searching c+1, c+2, ... cyclically. After reset the search starts at channel 0.
- R5: With every channel holding several complete packets, successive packets visit the channels in strict cyclic order, one packet each per round.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_last` and `out_src` hold their values on the next cycle.
- R7: A channel's `lnk_xoff` bit is 1 in the cycle after the edge that brings its FIFO occupancy to `XOFF_HI` or above.
- R8: Once raised, a channel's `lnk_xoff` bit stays 1 until the edge after which its occupancy is at or below `XOFF_LO`, and it is 0 from the following cycle.
- R9: With empty FIFOs and a ready output, a beat presented before edge k appears on the output after edge k+1.
- R10: If the owning channel's FIFO runs empty in the middle of a packet, the owner keeps the output. Other channels wait until its end beat has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_valid | input | NUM_CH | Per-channel beat strobe |
| lnk_data | input | NUM_CH*DATA_W | Per-channel beat data, channel c at bits c*DATA_W upward |
| lnk_last | input | NUM_CH | Per-channel end-of-packet flag |
| lnk_xoff | output | NUM_CH | Per-channel pause request toward the far end |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Output beat data |
| out_last | output | 1 | Output beat ends a packet |
| out_src | output | SRC_W | Channel that supplied the output beat |

## Verification
Under full load, every channel holds packets of a different length. The bench then checks that packets take turns in strict rotation. An arbiter that rotates priority on every beat instead of every packet would interleave the packets. One that fails to demote the last winner would serve a single channel repeatedly.

A packet with a hole in the middle tests lock retention: a design that releases the lock early would slip another channel's beat between the two halves. The bench follows each FIFO's occupancy cycle by cycle to check both pause-request thresholds. A single comparator without hysteresis would drop the request between the marks, and an off-by-one would move the edge by a cycle.

Stalls during loading check that a held output does not change under backpressure.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    typedef enum logic {
        ARB_OPEN   = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/rxm_fifo.sv
module rxm_fifo #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int XOFF_HI = 12,
    parameter int XOFF_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              xoff
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          xoff;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W:0] mem [DEPTH];
    logic push, pop;

    always_comb begin
        st_d = st_q;
        push = wr_en && (st_q.cnt != CW'(DEPTH));
        pop  = rd_en && (st_q.cnt != '0);
        if (push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        if (st_d.cnt >= CW'(XOFF_HI))      st_d.xoff = 1'b1;
        else if (st_d.cnt <= CW'(XOFF_LO)) st_d.xoff = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= {wr_last, wr_data};
    end

    assign rd_valid           = (st_q.cnt != '0);
    assign {rd_last, rd_data} = mem[st_q.rp];
    assign xoff               = st_q.xoff;

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.cnt != CW'(DEPTH)));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_valid);

    // R7
    xoff_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xoff |=> (!xoff || st_q.cnt >= CW'(XOFF_HI)));

    // R8
    xoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xoff |=> (xoff || st_q.cnt <= CW'(XOFF_LO)));

endmodule

// File: rtl/rxm_rr_arb.sv
module rxm_rr_arb
    import rxm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  req_last,
    input  logic          take,
    output logic [N-1:0]  pop,
    output logic [IW-1:0] sel,
    output logic          sel_valid
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        arb_mode_e     mode;
        logic [IW-1:0] owner;
        logic [IW-1:0] prev;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic [IW-1:0] cand;
    logic          found;
    logic          fire;

    always_comb begin
        int t;
        cand  = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            t = int'(st_q.prev) + k;
            if (t >= N) t = t - N;
            if (!found && req[t]) begin
                found = 1'b1;
                cand  = IW'(t);
            end
        end

        if (st_q.mode == ARB_LOCKED) begin
            sel       = st_q.owner;
            sel_valid = req[st_q.owner];
        end else begin
            sel       = cand;
            sel_valid = found;
        end

        fire = sel_valid && take;
        pop  = '0;
        if (fire) pop[sel] = 1'b1;

        st_d = st_q;
        if (fire) begin
            if (req_last[sel]) begin
                st_d.mode = ARB_OPEN;
                st_d.prev = sel;
            end else begin
                st_d.mode  = ARB_LOCKED;
                st_d.owner = sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= ARB_OPEN;
            st_q.owner <= '0;
            st_q.prev  <= IW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    // R2
    grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pop & ~req) == '0));

    // R10
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !req_last[sel]) |=> (pop == '0 || pop[$past(sel)]));

endmodule

// File: rtl/link_merge_rx.sv
module link_merge_rx #(
    parameter int NUM_CH     = 4,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int XOFF_HI    = 12,
    parameter int XOFF_LO    = 4,
    localparam int SRC_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        lnk_valid,
    input  logic [NUM_CH*DATA_W-1:0] lnk_data,
    input  logic [NUM_CH-1:0]        lnk_last,
    output logic [NUM_CH-1:0]        lnk_xoff,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_last,
    output logic [SRC_W-1:0]         out_src
);
    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
        logic              l;
        logic [SRC_W-1:0]  s;
    } out_st_t;

    logic [DATA_W-1:0] hd_data [NUM_CH];
    logic [NUM_CH-1:0] hd_valid;
    logic [NUM_CH-1:0] hd_last;
    logic [NUM_CH-1:0] pop;
    logic [SRC_W-1:0]  sel;
    logic              sel_valid;
    logic              take;
    out_st_t           o_d, o_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        rxm_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (FIFO_DEPTH),
            .XOFF_HI(XOFF_HI),
            .XOFF_LO(XOFF_LO)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lnk_valid[g]),
            .wr_data (lnk_data[g*DATA_W +: DATA_W]),
            .wr_last (lnk_last[g]),
            .rd_en   (pop[g]),
            .rd_valid(hd_valid[g]),
            .rd_data (hd_data[g]),
            .rd_last (hd_last[g]),
            .xoff    (lnk_xoff[g])
        );
    end

    assign take = !o_q.v || out_ready;

    rxm_rr_arb #(.N(NUM_CH)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (hd_valid),
        .req_last (hd_last),
        .take     (take),
        .pop      (pop),
        .sel      (sel),
        .sel_valid(sel_valid)
    );

    always_comb begin
        o_d = o_q;
        if (take) begin
            o_d.v = sel_valid;
            if (sel_valid) begin
                o_d.d = hd_data[sel];
                o_d.l = hd_last[sel];
                o_d.s = sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.v;
    assign out_data  = o_q.d;
    assign out_last  = o_q.l;
    assign out_src   = o_q.s;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_src)));

    // R3
    pkt_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (!out_valid || out_src == $past(out_src)));

endmodule

// File: tb/test_link_merge_rx.sv
module test_link_merge_rx;
    localparam int NC = 4;
    localparam int DW = 32;
    localparam int HI = 12;
    localparam int LO = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]    lnk_valid = '0;
    logic [NC*DW-1:0] lnk_data = '0;
    logic [NC-1:0]    lnk_last = '0;
    logic [NC-1:0]    lnk_xoff;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [DW-1:0]    out_data;
    logic             out_last;
    logic [SW-1:0]    out_src;

    int checks = 0;
    int fails = 0;
    int wr_cnt [NC];
    int shown [NC];
    bit xexp [NC];
    bit seen_v = 0;
    bit disp_counted = 0;
    logic [DW-1:0] log_data [$];
    logic          log_last [$];
    logic [SW-1:0] log_src  [$];

    always #5 clk = ~clk;

    link_merge_rx #(.NUM_CH(NC), .DATA_W(DW), .FIFO_DEPTH(16),
                    .XOFF_HI(HI), .XOFF_LO(LO)) i_link_merge_rx (
        .clk(clk), .rst_n(rst_n), .lnk_valid(lnk_valid), .lnk_data(lnk_data),
        .lnk_last(lnk_last), .lnk_xoff(lnk_xoff), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .out_src(out_src));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: count writes and consumption at the edge, sample at the falling edge.
    task automatic tick();
        @(posedge clk);
        for (int c = 0; c < NC; c++) if (lnk_valid[c] && rst_n) wr_cnt[c]++;
        if (seen_v && out_ready) disp_counted = 0;
        @(negedge clk);
        seen_v = out_valid;
        if (out_valid && !disp_counted) begin
            shown[out_src]++;
            disp_counted = 1;
            log_data.push_back(out_data);
            log_last.push_back(out_last);
            log_src.push_back(out_src);
        end else if (out_valid) begin
            // R6: stalled beat held
            chk(out_data == log_data[$] && out_src == log_src[$] && out_last == log_last[$],
                "R6 stall hold", out_data, log_data[$]);
        end
        for (int c = 0; c < NC; c++) begin
            int occ;
            occ = wr_cnt[c] - shown[c];
            if (occ >= HI) xexp[c] = 1;
            else if (occ <= LO) xexp[c] = 0;
            chk(lnk_xoff[c] == xexp[c], xexp[c] ? "R7 xoff level" : "R8 xoff level",
                32'(lnk_xoff[c]), 32'(xexp[c]));
        end
    endtask

    task automatic put(input int c, input logic [DW-1:0] d, input bit l);
        lnk_valid[c] = 1'b1;
        lnk_data[c*DW +: DW] = d;
        lnk_last[c] = l;
    endtask

    task automatic idle();
        lnk_valid = '0;
        lnk_last = '0;
    endtask

    task automatic expect_seq(input int idx, input int src, input logic [DW-1:0] d,
                              input bit l, input string req);
        if (idx >= log_src.size()) begin
            chk(0, req, 32'(log_src.size()), 32'(idx + 1));
        end else begin
            chk(log_src[idx] == SW'(src), req, 32'(log_src[idx]), 32'(src));
            chk(log_data[idx] == d, "R2 data", log_data[idx], d);
            chk(log_last[idx] == l, "R3 end flag", 32'(log_last[idx]), 32'(l));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin wr_cnt[c] = 0; shown[c] = 0; xexp[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(lnk_xoff == '0, "R1 xoff", 32'(lnk_xoff), 0);

        // R9: latency on an empty block
        out_ready = 1'b1;
        put(2, 32'h5A5A0001, 1'b1);
        tick();
        idle();
        chk(out_valid == 1'b0, "R9 not yet", 32'(out_valid), 0);
        tick();
        chk(out_valid == 1'b1, "R9 valid", 32'(out_valid), 1);
        chk(out_src == 2'd2 && out_data == 32'h5A5A0001, "R9 beat", out_data, 32'h5A5A0001);
        tick();

        // R5 R4 R3 R7: load all channels under stall, lengths c+2, three packets each
        log_data.delete(); log_last.delete(); log_src.delete();
        out_ready = 1'b0;
        for (int i = 0; i < 15; i++) begin
            idle();
            for (int c = 0; c < NC; c++) begin
                int len;
                len = c + 2;
                if (i < 3 * len)
                    put(c, {8'(c), 8'(i / len), 16'(i % len)}, (i % len) == len - 1);
            end
            tick();
        end
        idle();
        chk(lnk_xoff == 4'b1100, "R7 xoff after load", 32'(lnk_xoff), 32'hC);
        out_ready = 1'b1;
        for (int k = 0; k < 200 && log_src.size() < 42; k++) tick();
        tick();
        begin
            int idx;
            int order [4];
            idx = 0;
            order[0] = 3; order[1] = 0; order[2] = 1; order[3] = 2;
            for (int p = 0; p < 3; p++)
                for (int o = 0; o < 4; o++)
                    for (int b = 0; b < order[o] + 2; b++) begin
                        expect_seq(idx, order[o], {8'(order[o]), 8'(p), 16'(b)},
                                   b == order[o] + 1, "R5 rotation");
                        idx++;
                    end
        end
        chk(out_valid == 1'b0, "R2 drained", 32'(out_valid), 0);
        chk(lnk_xoff == '0, "R8 xoff released", 32'(lnk_xoff), 0);

        // R10: hole inside a packet keeps the owner
        log_data.delete(); log_last.delete(); log_src.delete();
        put(0, 32'hA0, 1'b0);
        tick();
        idle();
        put(1, 32'hB0, 1'b1);
        tick();
        idle();
        repeat (3) tick();
        put(0, 32'hA1, 1'b1);
        tick();
        idle();
        repeat (5) tick();
        expect_seq(0, 0, 32'hA0, 1'b0, "R10 first half");
        expect_seq(1, 0, 32'hA1, 1'b1, "R10 second half");
        expect_seq(2, 1, 32'hB0, 1'b1, "R10 waiter");

        // R4: after channel 1, search starts at 2
        log_data.delete(); log_last.delete(); log_src.delete();
        out_ready = 1'b0;
        put(0, 32'hC0, 1'b1);
        put(3, 32'hC3, 1'b1);
        tick();
        idle();
        tick();
        out_ready = 1'b1;
        repeat (4) tick();
        expect_seq(0, 3, 32'hC3, 1'b1, "R4 skip empty");
        expect_seq(1, 0, 32'hC0, 1'b1, "R4 wrap");

        // R4: after channel 0, order 1,2,0
        log_data.delete(); log_last.delete(); log_src.delete();
        out_ready = 1'b0;
        put(0, 32'hD0, 1'b1);
        put(1, 32'hD1, 1'b1);
        put(2, 32'hD2, 1'b1);
        tick();
        idle();
        tick();
        out_ready = 1'b1;
        repeat (5) tick();
        expect_seq(0, 1, 32'hD1, 1'b1, "R4 after 0");
        expect_seq(1, 2, 32'hD2, 1'b1, "R4 next");
        expect_seq(2, 0, 32'hD0, 1'b1, "R4 last");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule